// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Extend Flag

This block holds a processor's working accumulator together with a one-bit extend flag, and computes each new accumulator value in a small arithmetic/logic stage. One operand of that stage is always the accumulator itself. The other operand is a data-register word, or a narrow input-port byte that serves input transfers. Nothing else can write the accumulator: every change goes through the operation logic.

A sequencer drives a vector of operation-select strobes for one cycle. On the next rising clock edge the accumulator and the extend flag take the result. The operations are add with carry capture, AND, load from the data word, input transfer into the low byte, clear, complement, increment, rotations through the extend flag, and direct clear or complement of the extend flag. Subtraction is done in software by complementing and then incrementing. Three status outputs are decoded from the stored state, for use by conditional skips: accumulator zero, accumulator sign and extend zero.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and the extend flag are both cleared by that edge.
- R2: Add (`op_sel` bit 0) loads `acc_q + dr_in` modulo 2^16 and writes the carry out of bit 15 into the extend flag.
- R3: AND (bit 1) loads `acc_q & dr_in` and leaves the extend flag unchanged.
- R4: Load (bit 2) copies `dr_in` into the accumulator unchanged and leaves the extend flag unchanged.
- R5: Input transfer (bit 3) replaces accumulator bits 7..0 with `inp_in`, and keeps bits 15..8 and the extend flag.
- R6: Clear (bit 4) sets the accumulator to zero. Complement (bit 5) inverts every accumulator bit. Neither one changes the extend flag.
- R7: Increment (bit 6) adds one to the accumulator, wrapping from 0xFFFF to 0x0000, and leaves the extend flag unchanged. Complement followed by increment yields the two's-complement negative.
- R8: Rotate right (bit 7) puts the old extend flag into bit 15, shifts bits 15..1 down by one, and puts the old bit 0 into the extend flag.
- R9: Rotate left (bit 8) puts the old extend flag into bit 0, shifts bits 14..0 up by one, and puts the old bit 15 into the extend flag.
- R10: Extend clear (bit 9) and extend complement (bit 10) change only the extend flag. The accumulator is left as it was.
- R11: When several select bits are high, the lowest-numbered one is performed and the others are ignored. When no bit is high, both registers hold their values.
- R12: `acc_zero` is high exactly when the accumulator is zero, `acc_neg` equals accumulator bit 15, and `ext_zero` is high exactly when the extend flag is clear. All three follow the stored values within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 11 | Operation strobes; the bit meanings are given in R2 to R10 |
| dr_in | input | 16 | Data-register operand |
| inp_in | input | 8 | Input-port byte for input transfers |
| acc_q | output | 16 | Accumulator register |
| ext_q | output | 1 | Extend (carry) flag register |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_neg | output | 1 | Accumulator sign bit |
| ext_zero | output | 1 | Extend flag is clear |

## Verification
Each operation strobe takes effect on the first rising edge after it is driven. That means `acc_q` and `ext_q` show the result one cycle after the stimulus, and the three status flags follow within that same cycle, since no further register sits on their path. The bench changes inputs on falling edges and holds every select for exactly one rising edge. It then samples all five outputs at the next falling edge, half a cycle after the register update. The vector table is walked in order, so each entry's expected values are computed from the state left by the previous entry.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Operation strobe positions; lower index wins when several are raised.
  localparam int OP_ADD  = 0;
  localparam int OP_AND  = 1;
  localparam int OP_LOAD = 2;
  localparam int OP_INP  = 3;
  localparam int OP_CLR  = 4;
  localparam int OP_CMP  = 5;
  localparam int OP_INC  = 6;
  localparam int OP_ROR  = 7;
  localparam int OP_ROL  = 8;
  localparam int OP_CLRE = 9;
  localparam int OP_CMPE = 10;
  localparam int NUM_OPS = 11;

  typedef struct packed {
    logic acc_wr;
    logic ext_wr;
  } wr_en_t;

endpackage

// File: rtl/acc_alu_prio.sv
module acc_alu_prio #(
  parameter int N = 11
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pick
      if (i == 0) begin : g_first
        assign grant[i] = req[i];
      end else begin : g_rest
        assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate

  assign any = |req;

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  logic [DATA_W-1:0] opnd,
  input  logic [IN_W-1:0]   inp,
  output logic [DATA_W-1:0] sum,
  output logic              sum_cy,
  output logic [DATA_W-1:0] incr,
  output logic [DATA_W-1:0] rot_r,
  output logic              rot_r_ext,
  output logic [DATA_W-1:0] rot_l,
  output logic              rot_l_ext,
  output logic [DATA_W-1:0] in_merge
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] wide_sum;

  assign wide_sum = {1'b0, acc} + {1'b0, opnd};
  assign sum      = wide_sum[DATA_W-1:0];
  assign sum_cy   = wide_sum[DATA_W];

  assign incr = acc + {{(DATA_W-1){1'b0}}, 1'b1};

  assign rot_r     = {ext, acc[DATA_W-1:1]};
  assign rot_r_ext = acc[0];
  assign rot_l     = {acc[DATA_W-2:0], ext};
  assign rot_l_ext = acc[DATA_W-1];

  generate
    if (IN_W < DATA_W) begin : g_partial
      assign in_merge = {acc[DATA_W-1:IN_W], inp};
    end else begin : g_full
      assign in_merge = inp[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic [NUM_OPS-1:0] grant,
  input  logic [DATA_W-1:0]  acc,
  input  logic               ext,
  input  logic [DATA_W-1:0]  opnd,
  input  logic [IN_W-1:0]    inp,
  output logic [DATA_W-1:0]  nxt_acc,
  output logic               nxt_ext,
  output wr_en_t             wr
);

  logic [DATA_W-1:0] sum, incr, rot_r, rot_l, in_merge;
  logic              sum_cy, rot_r_ext, rot_l_ext;

  acc_alu_arith #(
    .DATA_W(DATA_W),
    .IN_W  (IN_W)
  ) arith_i (
    .acc      (acc),
    .ext      (ext),
    .opnd     (opnd),
    .inp      (inp),
    .sum      (sum),
    .sum_cy   (sum_cy),
    .incr     (incr),
    .rot_r    (rot_r),
    .rot_r_ext(rot_r_ext),
    .rot_l    (rot_l),
    .rot_l_ext(rot_l_ext),
    .in_merge (in_merge)
  );

  always_comb begin
    nxt_acc   = acc;
    nxt_ext   = ext;
    wr.acc_wr = 1'b0;
    wr.ext_wr = 1'b0;
    if (grant[OP_ADD]) begin
      nxt_acc = sum;        nxt_ext = sum_cy;
      wr.acc_wr = 1'b1;     wr.ext_wr = 1'b1;
    end else if (grant[OP_AND]) begin
      nxt_acc = acc & opnd; wr.acc_wr = 1'b1;
    end else if (grant[OP_LOAD]) begin
      nxt_acc = opnd;       wr.acc_wr = 1'b1;
    end else if (grant[OP_INP]) begin
      nxt_acc = in_merge;   wr.acc_wr = 1'b1;
    end else if (grant[OP_CLR]) begin
      nxt_acc = '0;         wr.acc_wr = 1'b1;
    end else if (grant[OP_CMP]) begin
      nxt_acc = ~acc;       wr.acc_wr = 1'b1;
    end else if (grant[OP_INC]) begin
      nxt_acc = incr;       wr.acc_wr = 1'b1;
    end else if (grant[OP_ROR]) begin
      nxt_acc = rot_r;      nxt_ext = rot_r_ext;
      wr.acc_wr = 1'b1;     wr.ext_wr = 1'b1;
    end else if (grant[OP_ROL]) begin
      nxt_acc = rot_l;      nxt_ext = rot_l_ext;
      wr.acc_wr = 1'b1;     wr.ext_wr = 1'b1;
    end else if (grant[OP_CLRE]) begin
      nxt_ext = 1'b0;       wr.ext_wr = 1'b1;
    end else if (grant[OP_CMPE]) begin
      nxt_ext = ~ext;       wr.ext_wr = 1'b1;
    end
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  output logic              is_zero,
  output logic              is_neg,
  output logic              ext_clr
);

  assign is_zero = (acc == '0);
  assign is_neg  = acc[DATA_W-1];
  assign ext_clr = ~ext;

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] op_sel,
  input  logic [DATA_W-1:0]  dr_in,
  input  logic [IN_W-1:0]    inp_in,
  output logic [DATA_W-1:0]  acc_q,
  output logic               ext_q,
  output logic               acc_zero,
  output logic               acc_neg,
  output logic               ext_zero
);

  logic [NUM_OPS-1:0] grant;
  logic               any_op;
  logic [DATA_W-1:0]  nxt_acc;
  logic               nxt_ext;
  wr_en_t             wr;

  acc_alu_prio #(.N(NUM_OPS)) prio_i (
    .req  (op_sel),
    .grant(grant),
    .any  (any_op)
  );

  acc_alu_unit #(
    .DATA_W(DATA_W),
    .IN_W  (IN_W)
  ) unit_i (
    .grant  (grant),
    .acc    (acc_q),
    .ext    (ext_q),
    .opnd   (dr_in),
    .inp    (inp_in),
    .nxt_acc(nxt_acc),
    .nxt_ext(nxt_ext),
    .wr     (wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (any_op) begin
      if (wr.acc_wr) acc_q <= nxt_acc;
      if (wr.ext_wr) ext_q <= nxt_ext;
    end
  end

  acc_alu_status #(.DATA_W(DATA_W)) status_i (
    .acc    (acc_q),
    .ext    (ext_q),
    .is_zero(acc_zero),
    .is_neg (acc_neg),
    .ext_clr(ext_zero)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !ext_q)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_sel == '0) |=> ($stable(acc_q) && $stable(ext_q))); // R11
  AST_AND_EXT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_sel[OP_AND] && !op_sel[OP_ADD]) |=> $stable(ext_q)); // R3
  AST_ROR_MOVE: assert property (@(posedge clk) disable iff (rst)
    (op_sel[OP_ROR] && op_sel[OP_ROR-1:0] == '0)
      |=> (ext_q == $past(acc_q[0]) && acc_q[DATA_W-1] == $past(ext_q))); // R8
  AST_ROL_MOVE: assert property (@(posedge clk) disable iff (rst)
    (op_sel[OP_ROL] && op_sel[OP_ROL-1:0] == '0)
      |=> (ext_q == $past(acc_q[DATA_W-1]) && acc_q[0] == $past(ext_q))); // R9
  AST_EXT_OP_ACC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_sel[OP_CLRE-1:0] == '0 && op_sel != '0) |=> $stable(acc_q)); // R10

endmodule

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb_top;

  localparam int DW = 16;
  localparam int IW = 8;
  localparam int NO = 11;
  localparam int VW = NO + DW + IW + DW + 1;
  localparam int NV = 21;

  // {op_sel, dr_in, inp_in, expected acc, expected ext}
  localparam logic [VW-1:0] VEC [NV] = '{
    {11'h004, 16'h1234, 8'h00, 16'h1234, 1'b0},
    {11'h001, 16'hF000, 8'h00, 16'h0234, 1'b1},
    {11'h002, 16'h00FF, 8'h00, 16'h0034, 1'b1},
    {11'h004, 16'hBEEF, 8'h00, 16'hBEEF, 1'b1},
    {11'h008, 16'h0000, 8'h5A, 16'hBE5A, 1'b1},
    {11'h080, 16'h0000, 8'h00, 16'hDF2D, 1'b0},
    {11'h100, 16'h0000, 8'h00, 16'hBE5A, 1'b1},
    {11'h400, 16'h0000, 8'h00, 16'hBE5A, 1'b0},
    {11'h020, 16'h0000, 8'h00, 16'h41A5, 1'b0},
    {11'h040, 16'h0000, 8'h00, 16'h41A6, 1'b0},
    {11'h010, 16'h0000, 8'h00, 16'h0000, 1'b0},
    {11'h040, 16'h0000, 8'h00, 16'h0001, 1'b0},
    {11'h400, 16'h0000, 8'h00, 16'h0001, 1'b1},
    {11'h200, 16'h0000, 8'h00, 16'h0001, 1'b0},
    {11'h400, 16'h0000, 8'h00, 16'h0001, 1'b1},
    {11'h004, 16'hFFFF, 8'h00, 16'hFFFF, 1'b1},
    {11'h040, 16'h0000, 8'h00, 16'h0000, 1'b1},
    {11'h001, 16'h0001, 8'h00, 16'h0001, 1'b0},
    {11'h003, 16'h0002, 8'h00, 16'h0003, 1'b0},
    {11'h000, 16'h0000, 8'h00, 16'h0003, 1'b0},
    {11'h110, 16'h0000, 8'h00, 16'h0000, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NO-1:0] op_sel = '0;
  logic [DW-1:0] dr_in = '0;
  logic [IW-1:0] inp_in = '0;
  logic [DW-1:0] acc_q;
  logic          ext_q, acc_zero, acc_neg, ext_zero;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  acc_alu_core dut_i (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .dr_in   (dr_in),
    .inp_in  (inp_in),
    .acc_q   (acc_q),
    .ext_q   (ext_q),
    .acc_zero(acc_zero),
    .acc_neg (acc_neg),
    .ext_zero(ext_zero)
  );

  function automatic string req_of(input logic [NO-1:0] op);
    if (op == '0 || $countones(op) > 1) return "R11";
    case (op)
      11'h001: return "R2";
      11'h002: return "R3";
      11'h004: return "R4";
      11'h008: return "R5";
      11'h010, 11'h020: return "R6";
      11'h040: return "R7";
      11'h080: return "R8";
      11'h100: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] ea, input logic ee);
    total++;
    if (acc_q !== ea || ext_q !== ee) begin
      bad++;
      $display("FAIL %s: acc=%h ext=%b expected acc=%h ext=%b", req, acc_q, ext_q, ea, ee);
    end
    total++;
    if (acc_zero !== (ea == '0) || acc_neg !== ea[DW-1] || ext_zero !== !ee) begin
      bad++;
      $display("FAIL R12 (%s): zero=%b neg=%b extz=%b expected %b %b %b", req,
               acc_zero, acc_neg, ext_zero, (ea == '0), ea[DW-1], !ee);
    end
  endtask

  // drive on a falling edge, one rising edge applies it, sample at the next falling edge
  task automatic step(input logic [NO-1:0] op, input logic [DW-1:0] d, input logic [IW-1:0] b);
    @(negedge clk);
    op_sel = op; dr_in = d; inp_in = b;
    @(negedge clk);
    op_sel = '0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-1 -: NO], v[DW+IW+DW : IW+DW+1], v[IW+DW : DW+1]);
      check(req_of(v[VW-1 -: NO]), v[DW:1], v[0]);
    end

    // R7: complement then increment negates; adding back produces carry
    step(11'h004, 16'h0005, 8'h00);
    step(11'h020, 16'h0000, 8'h00);
    step(11'h040, 16'h0000, 8'h00);
    check("R7", 16'hFFFB, 1'b0);
    step(11'h001, 16'h0009, 8'h00);
    check("R2", 16'h0004, 1'b1);

    // R2: sign overflow to zero with carry set
    step(11'h004, 16'h8000, 8'h00);
    step(11'h001, 16'h8000, 8'h00);
    check("R2", 16'h0000, 1'b1);

    // R5: input byte lands only in the low half
    step(11'h004, 16'h7F00, 8'h00);
    step(11'h008, 16'hFFFF, 8'hC3);
    check("R5", 16'h7FC3, 1'b1);

    // R11: a high-priority load beats rotate and extend ops
    step(11'h784, 16'h1111, 8'h00);
    check("R11", 16'h1111, 1'b1);

    // R1: reset wins over a pending add
    @(negedge clk);
    rst = 1'b1; op_sel = 11'h001; dr_in = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0; op_sel = '0;
    check("R1", 16'h0000, 1'b0);

    finish_run();
  end

endmodule